// File: doc/BRIEF.md
# Speculative Store Undo Logger

The logger sits between speculative tasks and a small word-addressed local memory. Each store carries an address, a value and the ID of the task issuing it. The block reads the owner ID kept next to the target word. If the owner is already the storing task, the store goes straight to memory. Otherwise the block first saves a three-word record: the word's address, then its previous owner ID, then its previous value. It then marks the word with the new owner and performs the store. All of this finishes in the cycle the store is accepted.

Records are packed into fixed-size sectors. A sector is taken from a LIFO stack of free sector indices when a task has no sector yet, or when its write pointer has reached the end of its current sector. Each task has a table entry that holds a valid flag, its first sector, its current sector and its write pointer. Sectors are linked backwards so that the chain can be walked from newest to oldest.

A commit walks the task's sector chain and returns one sector to the stack per cycle. A squash walks the task's records from newest to oldest. It restores each word's value and owner one record per cycle, and it returns each sector to the stack once that sector is empty. Owner tags are stored in the same array as the data, at a fixed offset of one page above each word.

Top module: `sul_undo_logger`

## Requirements
- R1: After reset every data word and every owner tag reads 0, `free_count` equals the number of sectors, `busy` is low and `st_ready` is high.
- R2: An accepted store whose target word has an owner different from `st_tid` logs the old address, owner and value. After the clock edge, `rd_data` shows the new value and `rd_tag` shows `st_tid`.
- R3: An accepted store whose target word is already owned by `st_tid` writes the value and makes no record. `free_count` is unchanged, and a later squash does not restore the value that was overwritten.
- R4: Each sector holds `SECT_RECS` records. A logging store takes one sector, lowering `free_count` by one, exactly when its task has no sector or its current sector is full.
- R5: `st_ready` is high only when the block is idle, at least one sector is free, and neither `squash_valid` nor `commit_valid` is asserted. A store offered while `st_ready` is low changes nothing.
- R6: A squash of a task that has records restores, from newest to oldest, the value and owner of every word the task logged. `busy` stays high for one cycle per record plus one cycle per sector.
- R7: When a squash ends, all of the squashed task's sectors are back on the free stack.
- R8: A commit of a task that has records returns its sectors, holding `busy` high for one cycle per sector. Memory values and owner tags are left as they are, including the committed task's ID.
- R9: A commit or squash naming a task that has no records has no effect: `busy` stays low and `free_count` and memory are unchanged.
- R10: When a squash and a commit are both valid for tasks with records, the squash is taken. Commands offered while `busy` is high are ignored.
- R11: `rd_data` and `rd_tag` show, without delay, the value and owner of the word at `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request can be taken |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store value |
| st_tid | input | TID_W | ID of the storing task |
| commit_valid | input | 1 | Commit request |
| commit_tid | input | TID_W | Task to commit |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | TID_W | Task to roll back |
| busy | output | 1 | Rollback or sector recycle in progress |
| free_count | output | CNT_W | Number of free sectors |
| rd_addr | input | ADDR_W | Observation address |
| rd_data | output | DATA_W | Value at `rd_addr` |
| rd_tag | output | TID_W | Owner ID at `rd_addr` |

## Verification
The assertions assume two things about the inputs: a store is counted only in a cycle where `st_ready` is high, and the free stack is never pushed beyond its capacity. The second holds because each sector is owned by at most one task entry at a time. The stimulus keeps task IDs in the range 1 to 7, so that tag 0 always means "no speculative owner". It also drives commands only between clock edges, and it deliberately offers stores, commits and squashes while the block is busy or out of sectors, to exercise the rule that such requests are dropped.

// File: rtl/sul_pkg.sv
package sul_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE     = 2'd0,
    ENG_ROLLBACK = 2'd1,
    ENG_RECYCLE  = 2'd2
  } eng_state_e;

  // Number of log words in one record: address, previous owner, previous value.
  localparam int REC_WORDS = 3;

  // First log word of a sector.
  function automatic int sect_base(input int sect, input int sect_words);
    return sect * sect_words;
  endfunction

  // One past the last log word of a sector.
  function automatic int sect_limit(input int sect, input int sect_words);
    return (sect + 1) * sect_words;
  endfunction

  // Owner tags live one page (depth words) above their data word.
  function automatic int tag_slot(input int addr, input int depth);
    return addr + depth;
  endfunction

endpackage

// File: rtl/sul_word_store.sv
module sul_word_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int TID_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TID_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [DATA_W-1:0] chk_data,
  output logic [TID_W-1:0]  chk_tag,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [TID_W-1:0]  rd_tag
);
  import sul_pkg::*;

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int MEM_WORDS = 2 * DEPTH;
  localparam int IDX_W     = ADDR_W + 1;

  logic [DATA_W-1:0] mem_q [MEM_WORDS];

  logic [IDX_W-1:0] wr_tidx, chk_tidx, rd_tidx;
  assign wr_tidx  = IDX_W'(tag_slot(int'(wr_addr), DEPTH));
  assign chk_tidx = IDX_W'(tag_slot(int'(chk_addr), DEPTH));
  assign rd_tidx  = IDX_W'(tag_slot(int'(rd_addr), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '{default: '0};
    end else if (wr_en) begin
      mem_q[IDX_W'(wr_addr)] <= wr_data;
      mem_q[wr_tidx]         <= DATA_W'(wr_tag);
    end
  end

  assign chk_data = mem_q[IDX_W'(chk_addr)];
  assign chk_tag  = mem_q[chk_tidx][TID_W-1:0];
  assign rd_data  = mem_q[IDX_W'(rd_addr)];
  assign rd_tag   = mem_q[rd_tidx][TID_W-1:0];

endmodule

// File: rtl/sul_sector_stack.sv
module sul_sector_stack #(
  parameter int NUM_SECT = 4,
  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int CNT_W   = $clog2(NUM_SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SECT_W-1:0] push_sect,
  input  logic              pop,
  output logic [SECT_W-1:0] top_sect,
  output logic [CNT_W-1:0]  count
);

  logic [SECT_W-1:0] stk_q [NUM_SECT];
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SECT; i++) stk_q[i] <= SECT_W'(i);
      cnt_q <= CNT_W'(NUM_SECT);
    end else if (push) begin
      stk_q[SECT_W'(cnt_q)] <= push_sect;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign top_sect = (cnt_q == '0) ? '0 : stk_q[SECT_W'(cnt_q - CNT_W'(1))];
  assign count    = cnt_q;

  // R4: a sector is only taken while one is free
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  // R7: returned sectors never exceed the stack's capacity
  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(NUM_SECT)));
  // R4: allocation and recycling never coincide
  p_push_pop_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/sul_log_buffer.sv
module sul_log_buffer #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int TID_W     = 3,
  parameter int LOG_WORDS = 24,
  parameter int PTR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [TID_W-1:0]  rec_tid,
  input  logic [DATA_W-1:0] rec_val,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [ADDR_W-1:0] out_addr,
  output logic [TID_W-1:0]  out_tid,
  output logic [DATA_W-1:0] out_val
);

  logic [DATA_W-1:0] log_q [LOG_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_q <= '{default: '0};
    end else if (wr_en) begin
      log_q[wr_ptr]                <= DATA_W'(rec_addr);
      log_q[wr_ptr + PTR_W'(1)]    <= DATA_W'(rec_tid);
      log_q[wr_ptr + PTR_W'(2)]    <= rec_val;
    end
  end

  logic [DATA_W-1:0] w0, w1, w2;
  always_comb begin
    int i;
    i  = int'(rd_ptr);
    w0 = (i     < LOG_WORDS) ? log_q[i]     : '0;
    w1 = (i + 1 < LOG_WORDS) ? log_q[i + 1] : '0;
    w2 = (i + 2 < LOG_WORDS) ? log_q[i + 2] : '0;
  end

  assign out_addr = w0[ADDR_W-1:0];
  assign out_tid  = w1[TID_W-1:0];
  assign out_val  = w2;

endmodule

// File: rtl/sul_undo_logger.sv
module sul_undo_logger #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int TID_W     = 3,
  parameter int NUM_SECT  = 4,
  parameter int SECT_RECS = 2,
  localparam int CNT_W    = $clog2(NUM_SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [TID_W-1:0]  st_tid,
  input  logic              commit_valid,
  input  logic [TID_W-1:0]  commit_tid,
  input  logic              squash_valid,
  input  logic [TID_W-1:0]  squash_tid,
  output logic              busy,
  output logic [CNT_W-1:0]  free_count,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [TID_W-1:0]  rd_tag
);
  import sul_pkg::*;

  localparam int SECT_WORDS = SECT_RECS * REC_WORDS;
  localparam int LOG_WORDS  = NUM_SECT * SECT_WORDS;
  localparam int PTR_W      = $clog2(LOG_WORDS + 1);
  localparam int SECT_W     = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int NTASK      = 1 << TID_W;

  function automatic logic [PTR_W-1:0] base_of(input logic [SECT_W-1:0] s);
    return PTR_W'(sect_base(int'(s), SECT_WORDS));
  endfunction

  function automatic logic [PTR_W-1:0] lim_of(input logic [SECT_W-1:0] s);
    return PTR_W'(sect_limit(int'(s), SECT_WORDS));
  endfunction

  // Per-task table and sector back links
  logic [NTASK-1:0]  tv_q;
  logic [SECT_W-1:0] tfirst_q [NTASK];
  logic [SECT_W-1:0] tcur_q   [NTASK];
  logic [PTR_W-1:0]  tptr_q   [NTASK];
  logic [SECT_W-1:0] sprev_q  [NUM_SECT];

  // Rollback / recycle engine
  eng_state_e        eng_q;
  logic [TID_W-1:0]  etid_q;
  logic [SECT_W-1:0] esect_q;
  logic [PTR_W-1:0]  eptr_q;

  // Named internal events
  logic              idle, squash_go, commit_go, st_fire, need_log, need_sect;
  logic              rb_empty, rb_restore, sect_push, chain_done;
  logic [PTR_W-1:0]  ins_ptr;
  logic [DATA_W-1:0] old_val;
  logic [TID_W-1:0]  old_tag;
  logic [SECT_W-1:0] fs_top;
  logic [CNT_W-1:0]  fs_count;
  logic [ADDR_W-1:0] lg_addr;
  logic [TID_W-1:0]  lg_tid;
  logic [DATA_W-1:0] lg_val;
  logic              ws_we;
  logic [ADDR_W-1:0] ws_addr;
  logic [DATA_W-1:0] ws_data;
  logic [TID_W-1:0]  ws_tag;

  assign idle      = (eng_q == ENG_IDLE);
  assign squash_go = idle && squash_valid && tv_q[squash_tid];
  assign commit_go = idle && !squash_go && commit_valid && tv_q[commit_tid];
  assign st_ready  = idle && (fs_count != '0) && !squash_valid && !commit_valid;
  assign st_fire   = st_valid && st_ready;
  assign need_log  = st_fire && (old_tag != st_tid);
  assign need_sect = need_log &&
                     (!tv_q[st_tid] || (tptr_q[st_tid] == lim_of(tcur_q[st_tid])));
  assign ins_ptr   = need_sect ? base_of(fs_top) : tptr_q[st_tid];

  assign rb_empty   = (eptr_q == base_of(esect_q));
  assign rb_restore = (eng_q == ENG_ROLLBACK) && !rb_empty;
  assign sect_push  = ((eng_q == ENG_ROLLBACK) && rb_empty) || (eng_q == ENG_RECYCLE);
  assign chain_done = sect_push && (esect_q == tfirst_q[etid_q]);

  assign ws_we   = st_fire || rb_restore;
  assign ws_addr = rb_restore ? lg_addr : st_addr;
  assign ws_data = rb_restore ? lg_val  : st_data;
  assign ws_tag  = rb_restore ? lg_tid  : st_tid;

  sul_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W)) u_words (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ws_we), .wr_addr(ws_addr), .wr_data(ws_data), .wr_tag(ws_tag),
    .chk_addr(st_addr), .chk_data(old_val), .chk_tag(old_tag),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_tag(rd_tag)
  );

  sul_sector_stack #(.NUM_SECT(NUM_SECT)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(sect_push), .push_sect(esect_q),
    .pop(need_sect), .top_sect(fs_top), .count(fs_count)
  );

  sul_log_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W),
                   .LOG_WORDS(LOG_WORDS), .PTR_W(PTR_W)) u_log (
    .clk(clk), .rst_n(rst_n),
    .wr_en(need_log), .wr_ptr(ins_ptr),
    .rec_addr(st_addr), .rec_tid(old_tag), .rec_val(old_val),
    .rd_ptr(eptr_q - PTR_W'(REC_WORDS)),
    .out_addr(lg_addr), .out_tid(lg_tid), .out_val(lg_val)
  );

  // Task table
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tv_q     <= '0;
      tfirst_q <= '{default: '0};
      tcur_q   <= '{default: '0};
      tptr_q   <= '{default: '0};
      sprev_q  <= '{default: '0};
    end else begin
      if (need_log) begin
        tptr_q[st_tid] <= ins_ptr + PTR_W'(REC_WORDS);
        if (need_sect) begin
          tcur_q[st_tid]  <= fs_top;
          sprev_q[fs_top] <= tcur_q[st_tid];
          if (!tv_q[st_tid]) begin
            tfirst_q[st_tid] <= fs_top;
            tv_q[st_tid]     <= 1'b1;
          end
        end
      end
      if (chain_done) tv_q[etid_q] <= 1'b0;
    end
  end

  // Engine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_q   <= ENG_IDLE;
      etid_q  <= '0;
      esect_q <= '0;
      eptr_q  <= '0;
    end else begin
      unique case (eng_q)
        ENG_IDLE: begin
          if (squash_go) begin
            eng_q   <= ENG_ROLLBACK;
            etid_q  <= squash_tid;
            esect_q <= tcur_q[squash_tid];
            eptr_q  <= tptr_q[squash_tid];
          end else if (commit_go) begin
            eng_q   <= ENG_RECYCLE;
            etid_q  <= commit_tid;
            esect_q <= tcur_q[commit_tid];
          end
        end
        ENG_ROLLBACK: begin
          if (!rb_empty) begin
            eptr_q <= eptr_q - PTR_W'(REC_WORDS);
          end else if (chain_done) begin
            eng_q <= ENG_IDLE;
          end else begin
            esect_q <= sprev_q[esect_q];
            eptr_q  <= lim_of(sprev_q[esect_q]);
          end
        end
        ENG_RECYCLE: begin
          if (chain_done) eng_q <= ENG_IDLE;
          else            esect_q <= sprev_q[esect_q];
        end
        default: eng_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy       = !idle;
  assign free_count = fs_count;

  // R6: the rollback pointer stays inside the sector being unwound
  p_rb_ptr_in_sector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_q == ENG_ROLLBACK) |->
      (eptr_q >= base_of(esect_q)) && (eptr_q <= lim_of(esect_q)));
  // R4: an active task's write pointer lies past its sector base and within its limit
  p_task_ptr_in_sector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tv_q[st_tid] |->
      (tptr_q[st_tid] > base_of(tcur_q[st_tid])) &&
      (tptr_q[st_tid] <= lim_of(tcur_q[st_tid])));
  // R2: a logging store leaves its task with a live table entry
  p_log_opens_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    need_log |=> tv_q[$past(st_tid)]);
  // R7: when the engine returns to idle, the task it served has no entry left
  p_engine_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && ($past(eng_q) != ENG_IDLE)) |-> !tv_q[$past(etid_q)]);
  // R5: a store is never taken while the engine runs
  p_no_store_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_q != ENG_IDLE) |-> !ws_we || rb_restore);

endmodule

// File: tb/sul_undo_logger_tb.sv
module sul_undo_logger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4, DATA_W = 16, TID_W = 3, NUM_SECT = 4, SECT_RECS = 2;
  localparam int CNT_W = $clog2(NUM_SECT + 1);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NTASK = 1 << TID_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, commit_valid = 1'b0, squash_valid = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] st_data = '0;
  logic [TID_W-1:0]  st_tid = '0, commit_tid = '0, squash_tid = '0;
  logic st_ready, busy;
  logic [CNT_W-1:0]  free_count;
  logic [DATA_W-1:0] rd_data;
  logic [TID_W-1:0]  rd_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sul_undo_logger #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W),
                    .NUM_SECT(NUM_SECT), .SECT_RECS(SECT_RECS)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_tid(st_tid),
    .commit_valid(commit_valid), .commit_tid(commit_tid),
    .squash_valid(squash_valid), .squash_tid(squash_tid),
    .busy(busy), .free_count(free_count),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_tag(rd_tag)
  );

  int nchk = 0, nfail = 0, ncyc = 0;

  // Reference model
  int m_data [DEPTH];
  int m_tag  [DEPTH];
  int m_free;
  bit m_valid [NTASK];
  int m_ra [NTASK][$];
  int m_rt [NTASK][$];
  int m_rv [NTASK][$];
  int m_nsect [NTASK];
  int m_busy_left;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, ncyc);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = 0; m_tag[i] = 0; end
    for (int t = 0; t < NTASK; t++) begin
      m_valid[t] = 0; m_nsect[t] = 0;
      m_ra[t].delete(); m_rt[t].delete(); m_rv[t].delete();
    end
    m_free = NUM_SECT;
    m_busy_left = 0;
  endfunction

  function automatic void model_release(input int t);
    m_free += m_nsect[t];
    m_nsect[t] = 0;
    m_valid[t] = 0;
    m_ra[t].delete(); m_rt[t].delete(); m_rv[t].delete();
  endfunction

  function automatic void model_step();
    bit sq, cm, rdy;
    if (m_busy_left > 0) begin m_busy_left--; return; end
    sq  = squash_valid && m_valid[squash_tid];
    cm  = !sq && commit_valid && m_valid[commit_tid];
    rdy = (m_free != 0) && !squash_valid && !commit_valid;
    if (sq) begin
      int t = int'(squash_tid);
      m_busy_left = m_ra[t].size() + m_nsect[t];
      for (int k = m_ra[t].size() - 1; k >= 0; k--) begin
        m_data[m_ra[t][k]] = m_rv[t][k];
        m_tag[m_ra[t][k]]  = m_rt[t][k];
      end
      model_release(t);
    end else if (cm) begin
      int t = int'(commit_tid);
      m_busy_left = m_nsect[t];
      model_release(t);
    end else if (st_valid && rdy) begin
      int t = int'(st_tid);
      int a = int'(st_addr);
      if (m_tag[a] != t) begin
        if (m_ra[t].size() % SECT_RECS == 0) begin m_free--; m_nsect[t]++; end
        m_ra[t].push_back(a); m_rt[t].push_back(m_tag[a]); m_rv[t].push_back(m_data[a]);
        m_valid[t] = 1;
      end
      m_tag[a]  = t;
      m_data[a] = int'(st_data);
    end
  endfunction

  // One clock: compare outputs against the model, advance the model, pass the edge.
  task automatic cycle();
    bit idle_m;
    #1;
    idle_m = (m_busy_left == 0);
    check("R6 busy", int'(busy), int'(!idle_m));
    check("R5 ready", int'(st_ready),
          int'(idle_m && m_free != 0 && !squash_valid && !commit_valid));
    if (idle_m) begin
      check("R4 free_count", int'(free_count), m_free);
      check("R11 rd_data", int'(rd_data), m_data[rd_addr]);
      check("R11 rd_tag", int'(rd_tag), m_tag[rd_addr]);
    end
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic store(input int t, input int a, input int d);
    st_valid = 1'b1; st_tid = TID_W'(t); st_addr = ADDR_W'(a); st_data = DATA_W'(d);
    cycle();
    st_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 64 && m_busy_left > 0; i++) cycle();
    cycle();
  endtask

  task automatic peek(input string req, input int a, input int d, input int t);
    rd_addr = ADDR_W'(a);
    #1;
    check(req, int'(rd_data), d);
    check(req, int'(rd_tag), t);
  endtask

  // Watchdog
  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 100000) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_addr = 5;
    #1;
    check("R1 ready", int'(st_ready), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 free", int'(free_count), NUM_SECT);
    peek("R1 word", 5, 0, 0);

    // R2 first store logs and takes a sector
    store(1, 3, 'h11);
    peek("R2 word", 3, 'h11, 1);
    check("R4 first sector", int'(free_count), 3);
    // R3 same-owner store: no record
    store(1, 3, 'h22);
    peek("R3 word", 3, 'h22, 1);
    check("R3 no sector", int'(free_count), 3);
    // R4 fill sector then spill
    store(1, 4, 'h33);
    check("R4 sector not full", int'(free_count), 3);
    store(1, 5, 'h44);
    check("R4 new sector", int'(free_count), 2);
    store(2, 3, 'h55);
    check("R4 task2 sector", int'(free_count), 1);

    // R6 squash task 2: one record, one sector -> busy 2 cycles
    squash_valid = 1'b1; squash_tid = 2; cycle(); squash_valid = 1'b0;
    #1; check("R6 busy after squash", int'(busy), 1);
    wait_idle();
    peek("R6 restore", 3, 'h22, 1);
    check("R7 free after squash", int'(free_count), 2);

    // R10 squash beats commit; commands during busy ignored
    squash_valid = 1'b1; squash_tid = 1; commit_valid = 1'b1; commit_tid = 1;
    cycle();
    squash_valid = 1'b0;
    commit_tid = 1;          // commit held while busy: must be dropped
    cycle(); cycle();
    commit_valid = 1'b0;
    wait_idle();
    peek("R10 squash taken", 3, 0, 0);
    peek("R6 oldest restored", 5, 0, 0);
    check("R7 all sectors back", int'(free_count), NUM_SECT);

    // R9 commit of task with no records
    commit_valid = 1'b1; commit_tid = 5; cycle(); commit_valid = 1'b0;
    #1; check("R9 no busy", int'(busy), 0);
    check("R9 free unchanged", int'(free_count), NUM_SECT);
    cycle();

    // R8 commit keeps data and owner
    store(3, 7, 'h77);
    store(3, 8, 'h88);
    commit_valid = 1'b1; commit_tid = 3; cycle(); commit_valid = 1'b0;
    #1; check("R8 busy one cycle", int'(busy), 1);
    wait_idle();
    peek("R8 data kept", 7, 'h77, 3);
    check("R8 free", int'(free_count), NUM_SECT);

    // R5 exhaust sectors, then offer a store
    store(1, 10, 1); store(2, 11, 2); store(4, 12, 3); store(5, 13, 4);
    #1; check("R5 no free, not ready", int'(st_ready), 0);
    store(6, 14, 'h99);
    peek("R5 dropped store", 14, 0, 0);
    for (int t = 1; t <= 5; t++) begin
      commit_valid = 1'b1; commit_tid = TID_W'(t); cycle(); commit_valid = 1'b0;
      wait_idle();
    end

    // Random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      int r = int'($urandom_range(0, 99));
      rd_addr = ADDR_W'($urandom_range(0, DEPTH - 1));
      st_valid = 1'b0; squash_valid = 1'b0; commit_valid = 1'b0;
      if (r < 70) begin
        st_valid = 1'b1; st_tid = TID_W'($urandom_range(1, NTASK - 1));
        st_addr = ADDR_W'($urandom_range(0, 7)); st_data = DATA_W'($urandom);
      end else if (r < 80) begin
        squash_valid = 1'b1; squash_tid = TID_W'($urandom_range(1, NTASK - 1));
        if (r < 74) begin commit_valid = 1'b1; commit_tid = TID_W'($urandom_range(1, NTASK - 1)); end
      end else if (r < 90) begin
        commit_valid = 1'b1; commit_tid = TID_W'($urandom_range(1, NTASK - 1));
      end
      cycle();
    end
    st_valid = 1'b0; squash_valid = 1'b0; commit_valid = 1'b0;
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule